// File: doc/BRIEF.md
# Multi-format synchronous serial master

This block is a synchronous serial master. One shift engine drives three frame formats: a select-framed SPI-style format with selectable clock polarity and phase, a pulse-framed TI-style format, and a half-duplex Microwire-style command/response format. The host writes transmit words into an 8-entry transmit FIFO and reads received words from an 8-entry receive FIFO. Configuration inputs set the format, the frame size (4 to 16 bits), and the bit clock. The bit clock comes from the system clock through an even prescaler followed by a divider.

A new frame starts whenever the engine is idle and the transmit FIFO holds a word. Each frame shifts data out and in most-significant bit first. Words shorter than 16 bits sit right-justified in both FIFOs. When a frame completes while the receive FIFO is full, the received word is discarded and a sticky overrun flag is raised. Configuration is expected to stay stable while `busy` is high.

Top module: `sync_serial_master`

## Requirements
- R1: `cfg_fmt` selects the format with these encodings: 0 is SPI-style, 1 is TI-style, 2 is Microwire-style, and 3 behaves exactly like 0.
- R2: The frame size N is `cfg_size`+1 for `cfg_size` from 3 to 15, and 4 for smaller values. Transmit uses bits [N-1:0] of the word. Received words land in bits [N-1:0] with all higher bits zero.
- R3: Each FIFO holds 8 words of 16 bits. `tx_full` is high while 8 words wait, and a write while full is dropped. `rx_rdata` shows the oldest received word whenever `rx_empty` is low, and `rx_rd` removes it. `rx_full` is high at 8 words.
- R4: One SCLK period lasts P*(1+`cfg_divide`) clock cycles. P is `cfg_prescale` with bit 0 ignored, and a value of 0 acts as 2.
- R5: A frame begins when the engine is idle and the transmit FIFO is not empty. Bits go out and come in MSB first. SPI-style and TI-style frames shift both directions at the same time.
- R6: In SPI-style format, SCLK rests at `cfg_cpol`. With `cfg_cpha`=0 data is sampled on the first edge of each bit; with `cfg_cpha`=1 it is sampled on the second edge. `sel_frm` is low for the whole frame and high for at least one cycle between frames.
- R7: In TI-style format, SCLK rests low and `sel_frm` rests low. `sel_frm` is high for exactly one bit period immediately before the MSB. Data changes on rising SCLK and is sampled on falling SCLK.
- R8: In Microwire-style format, `sel_frm` is low for the frame. Bits [7:0] of the word go out first as a command, MSB first, with `txd` changing on falling SCLK. One idle turnaround bit follows, then N response bits are sampled on rising SCLK. `txd` is low from the end of the command to the end of the frame.
- R9: A frame that ends while `rx_full` is high leaves the receive FIFO unchanged and sets `overrun`, which stays high until reset.
- R10: After reset both FIFOs are empty, `overrun` and `busy` are low, `txd` is low, and SCLK and `sel_frm` rest at the idle levels of the selected format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit FIFO |
| tx_wdata | input | 16 | Transmit word, right-justified |
| tx_full | output | 1 | Transmit FIFO holds 8 words |
| tx_empty | output | 1 | Transmit FIFO is empty |
| rx_rd | input | 1 | Pop the oldest received word |
| rx_rdata | output | 16 | Oldest received word, right-justified |
| rx_empty | output | 1 | Receive FIFO is empty |
| rx_full | output | 1 | Receive FIFO holds 8 words |
| overrun | output | 1 | Sticky flag: a received word was dropped |
| busy | output | 1 | A frame is in progress |
| cfg_fmt | input | 2 | Frame format select |
| cfg_size | input | 4 | Frame size minus one |
| cfg_prescale | input | 8 | Even clock prescaler |
| cfg_divide | input | 8 | Bit-rate divider |
| cfg_cpol | input | 1 | SPI-style idle clock level |
| cfg_cpha | input | 1 | SPI-style sampling edge select |
| sclk | output | 1 | Serial clock |
| sel_frm | output | 1 | Select (SPI/Microwire, active low) or frame pulse (TI, active high) |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |

## Verification
Every cycle, the assertions check that the FIFOs neither gain nor lose an entry when full or empty, that the prescaler count stays inside its limit, and that the slot counter never passes the last slot of the latched format. They also check that a started frame opens at slot zero, that received words are right-justified, and that the overrun flag never falls. Only the bench's scenarios can show that the right bits appear on the wire in the right order on the right SCLK edges for each format and each polarity/phase choice. The same holds for the measured bit period across prescaler and divider settings, for the dropped write when the transmit FIFO is full, and for the content kept when a frame ends with the receive FIFO full.

// File: rtl/ssm_pkg.sv
// Shared types for the synchronous serial master.
// Assumes: nothing beyond IEEE 1800-2017.
package ssm_pkg;
    typedef enum logic [1:0] {
        FMT_SPI = 2'd0,
        FMT_TI  = 2'd1,
        FMT_MW  = 2'd2
    } fmt_e;
endpackage

// File: rtl/ssm_fifo.sv
// Synchronous first-in first-out buffer with show-ahead read data.
// Assumes: DEPTH is a power of two; a push while full and a pop while
// empty are ignored.
module ssm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int AW  = $clog2(DEPTH);
    localparam int CTW = AW + 1;

    logic [W-1:0]   mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [CTW-1:0] cnt;
    logic           do_push, do_pop;

    // Occupancy flags and qualified strobes.
    always_comb begin
        full    = (cnt == CTW'(DEPTH));
        empty   = (cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        rdata   = mem[rp];
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            cnt <= cnt + CTW'(do_push) - CTW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    // R3
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/ssm_bitclk.sv
// Two-stage bit clock generator: a prescaler of half the even setting
// followed by a divider of (divide+1). It emits one half_tick per SCLK
// half period, so a full period is prescale*(divide+1) cycles.
// Assumes: counters restart whenever en is low, so the first half of a
// frame has full length; bit 0 of prescale is ignored, 0 acts as 2.
module ssm_bitclk #(
    parameter int PW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] prescale,
    input  logic [DW-1:0] divide,
    output logic          half_tick
);
    localparam int HW = PW - 1;

    logic [HW-1:0] pre_half, pcnt;
    logic [DW-1:0] dcnt;
    logic          pre_tick;

    // Half of the prescale value, never below one cycle.
    always_comb begin
        pre_half  = (prescale[PW-1:1] == '0) ? HW'(1) : prescale[PW-1:1];
        pre_tick  = en && (pcnt == pre_half - HW'(1));
        half_tick = pre_tick && (dcnt == divide);
    end

    // Prescaler and divider counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (pre_tick) begin
            pcnt <= '0;
            dcnt <= (dcnt == divide) ? '0 : dcnt + DW'(1);
        end else begin
            pcnt <= pcnt + HW'(1);
        end
    end

    // R4
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (pcnt < pre_half));
endmodule

// File: rtl/ssm_engine.sv
// Frame shift engine shared by the three formats. A frame is a run of
// slots, each one SCLK period split into two halves: data launches at
// the start of a slot and is sampled at its midpoint.
//   SPI-style: N data slots.
//   TI-style:  one frame-pulse slot, then N data slots.
//   Microwire-style: 8 command slots, 1 turnaround slot, N response slots.
// Assumes: configuration is stable while active; half_tick marks the
// end of each half period.
module ssm_engine
    import ssm_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CMD_W = 8,
    parameter int ZW    = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fmt_cfg,
    input  logic [ZW-1:0] size_cfg,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          tx_avail,
    input  logic [DW-1:0] tx_word,
    output logic          tx_pop,
    input  logic          rx_full,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          ovr_set,
    input  logic          half_tick,
    output logic          active,
    output logic          sclk,
    output logic          fss,
    output logic          txd,
    input  logic          rxd
);
    localparam int CW = $clog2(DW + 1);
    localparam int SW = $clog2(DW + CMD_W + 2);

    fmt_e          fmt_in, fmt_q;
    logic          half, lvl_q, rx_slot, frame_end, start;
    logic [SW-1:0] slot, last_slot;
    logic [CW-1:0] nb_in, nb_q;
    logic [DW-1:0] tx_sh, rx_sh;

    // Decode live configuration: format and effective frame size.
    always_comb begin
        case (fmt_cfg)
            2'd1:    fmt_in = FMT_TI;
            2'd2:    fmt_in = FMT_MW;
            default: fmt_in = FMT_SPI;
        endcase
        nb_in = (size_cfg < ZW'(3)) ? CW'(4) : CW'(size_cfg) + CW'(1);
    end

    // Slot limits and receive windows of the latched format.
    always_comb begin
        case (fmt_q)
            FMT_TI: begin
                last_slot = SW'(nb_q);
                rx_slot   = (slot != '0);
            end
            FMT_MW: begin
                last_slot = SW'(nb_q) + SW'(CMD_W);
                rx_slot   = (slot >= SW'(CMD_W + 1));
            end
            default: begin
                last_slot = SW'(nb_q) - SW'(1);
                rx_slot   = 1'b1;
            end
        endcase
        start     = !active && tx_avail;
        frame_end = active && half_tick && half && (slot == last_slot);
    end

    // Frame sequencing, serialisation and deserialisation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            half   <= 1'b0;
            slot   <= '0;
            fmt_q  <= FMT_SPI;
            nb_q   <= CW'(4);
            lvl_q  <= 1'b0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (start) begin
            active <= 1'b1;
            half   <= 1'b0;
            slot   <= '0;
            fmt_q  <= fmt_in;
            nb_q   <= nb_in;
            lvl_q  <= (fmt_in == FMT_SPI) ? (cpol ^ cpha) : (fmt_in == FMT_TI);
            tx_sh  <= (fmt_in == FMT_MW) ? {tx_word[CMD_W-1:0], {(DW-CMD_W){1'b0}}}
                                         : tx_word << (CW'(DW) - nb_in);
            rx_sh  <= '0;
        end else if (active && half_tick) begin
            if (!half) begin
                half <= 1'b1;
                if (rx_slot) rx_sh <= {rx_sh[DW-2:0], rxd};
            end else if (slot == last_slot) begin
                active <= 1'b0;
            end else begin
                slot <= slot + SW'(1);
                half <= 1'b0;
                if (!(fmt_q == FMT_TI && slot == '0)) tx_sh <= tx_sh << 1;
            end
        end
    end

    // Pin levels and FIFO strobes.
    always_comb begin
        tx_pop  = start;
        rx_word = rx_sh;
        rx_push = frame_end && !rx_full;
        ovr_set = frame_end && rx_full;
        sclk    = active ? (half ? ~lvl_q : lvl_q)
                         : ((fmt_in == FMT_SPI) ? cpol : 1'b0);
        fss     = active ? ((fmt_q == FMT_TI) ? (slot == '0) : 1'b0)
                         : (fmt_in != FMT_TI);
        txd     = active && !(fmt_q == FMT_TI && slot == '0) && tx_sh[DW-1];
    end

    // R5
    start_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (active && !half && slot == '0));
    // R5
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (slot <= last_slot));
    // R2
    rx_justify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ((rx_word >> nb_q) == '0));
endmodule

// File: rtl/sync_serial_master.sv
// Top of the multi-format synchronous serial master: transmit FIFO,
// bit clock generator, shift engine, receive FIFO and overrun flag.
// Assumes: configuration inputs change only while busy is low.
module sync_serial_master #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int PRE_W  = 8,
    parameter int DIV_W  = 8,
    parameter int SIZE_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic              busy,
    input  logic [1:0]        cfg_fmt,
    input  logic [SIZE_W-1:0] cfg_size,
    input  logic [PRE_W-1:0]  cfg_prescale,
    input  logic [DIV_W-1:0]  cfg_divide,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    output logic              sclk,
    output logic              sel_frm,
    output logic              txd,
    input  logic              rxd
);
    logic              tx_pop, rx_push, ovr_set, half_tick, active;
    logic [DATA_W-1:0] tx_word, rx_word;

    ssm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_wdata),
        .full(tx_full), .pop(tx_pop), .rdata(tx_word), .empty(tx_empty)
    );

    ssm_bitclk #(.PW(PRE_W), .DW(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(active), .prescale(cfg_prescale),
        .divide(cfg_divide), .half_tick(half_tick)
    );

    ssm_engine #(.DW(DATA_W), .CMD_W(8), .ZW(SIZE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .fmt_cfg(cfg_fmt), .size_cfg(cfg_size),
        .cpol(cfg_cpol), .cpha(cfg_cpha), .tx_avail(!tx_empty),
        .tx_word(tx_word), .tx_pop(tx_pop), .rx_full(rx_full),
        .rx_push(rx_push), .rx_word(rx_word), .ovr_set(ovr_set),
        .half_tick(half_tick), .active(active), .sclk(sclk),
        .fss(sel_frm), .txd(txd), .rxd(rxd)
    );

    ssm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .full(rx_full), .pop(rx_rd), .rdata(rx_rdata), .empty(rx_empty)
    );

    // Sticky overrun flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (ovr_set) overrun <= 1'b1;
    end

    always_comb busy = active;

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

// File: tb/sim_sync_serial_master.sv
// Bench: acts as the serial peripheral, decoding each format from its
// pin behaviour, and compares wire bits, bit periods and received words
// with values computed from the requirements.
module sim_sync_serial_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wr = 1'b0, rx_rd = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        tx_full, tx_empty, rx_empty, rx_full, overrun, busy;
    logic [15:0] rx_rdata;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [3:0]  cfg_size = 4'd7;
    logic [7:0]  cfg_prescale = 8'd2, cfg_divide = 8'd0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic        sclk, sel_frm, txd;
    logic        rxd = 1'b0;

    sync_serial_master u0 (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .rx_empty(rx_empty), .rx_full(rx_full),
        .overrun(overrun), .busy(busy), .cfg_fmt(cfg_fmt),
        .cfg_size(cfg_size), .cfg_prescale(cfg_prescale),
        .cfg_divide(cfg_divide), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .sclk(sclk), .sel_frm(sel_frm), .txd(txd), .rxd(rxd)
    );

    always #2.5 clk = ~clk;  // 200 MHz

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [15:0] tx_q [128];
    logic [15:0] resp_q [128];
    logic [15:0] got_q [128];
    int          cnt_q [128];
    int          per_q [128];
    bit          bad_q [128];

    // Bench-side slave state.
    int          s_idx = 0, s_cnt = 0, s_t0 = 0, s_per = 0;
    bit          s_on = 0, s_bad = 0;
    logic [15:0] s_got = '0;
    logic        prev_sclk = 1'b0, prev_fss = 1'b1;

    function automatic int eff_fmt();
        return (cfg_fmt == 2'd1) ? 1 : (cfg_fmt == 2'd2) ? 2 : 0;
    endfunction
    function automatic int nbits();
        return (cfg_size < 4'd3) ? 4 : int'(cfg_size) + 1;
    endfunction
    function automatic int period(input int pre, input int dv);
        int p = pre & 254;
        if (p == 0) p = 2;
        return p * (dv + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            summary();
        end
    end

    task automatic s_sample(input bit keep);
        s_cnt++;
        if (keep) s_got = {s_got[14:0], txd};
        if (s_cnt == 1) s_t0 = cyc;
        else if (s_cnt == 2) s_per = cyc - s_t0;
    endtask

    task automatic s_begin();
        s_on = 1; s_cnt = 0; s_got = '0; s_per = 0; s_bad = 0;
    endtask

    task automatic s_finish();
        got_q[s_idx] = s_got; cnt_q[s_idx] = s_cnt;
        per_q[s_idx] = s_per; bad_q[s_idx] = s_bad;
        s_idx++; s_on = 0;
    endtask

    // Peripheral model, evaluated away from the active edge.
    always @(negedge clk) begin
        int nb;
        nb = nbits();
        if (!rst_n) begin
            s_on = 0; rxd = 1'b0;
        end else begin
            case (eff_fmt())
                0: begin  // SPI-style
                    if (prev_fss && !sel_frm) begin
                        s_begin(); rxd = resp_q[s_idx][nb-1];
                    end
                    if (s_on && sclk != prev_sclk) begin
                        if (sclk == (cfg_cpol ^ !cfg_cpha)) s_sample(1'b1);
                        else if (s_cnt > 0 && s_cnt < nb) rxd = resp_q[s_idx][nb-1-s_cnt];
                    end
                    if (s_on && !prev_fss && sel_frm) s_finish();
                end
                1: begin  // TI-style
                    if (!prev_fss && sel_frm) s_on = 0;
                    if (prev_fss && !sel_frm) begin
                        s_begin(); rxd = resp_q[s_idx][nb-1];
                    end
                    if (s_on && prev_sclk && !sclk) begin
                        s_sample(1'b1);
                        if (s_cnt == nb) s_finish();
                    end else if (s_on && !prev_sclk && sclk && s_cnt > 0 && s_cnt < nb) begin
                        rxd = resp_q[s_idx][nb-1-s_cnt];
                    end
                end
                default: begin  // Microwire-style
                    if (prev_fss && !sel_frm) begin
                        s_begin(); rxd = 1'b0;
                    end
                    if (s_on && !prev_sclk && sclk) begin
                        s_sample(s_cnt < 8);
                        if (s_cnt > 8 && txd) s_bad = 1;
                    end else if (s_on && prev_sclk && !sclk && s_cnt >= 9 && s_cnt - 9 < nb) begin
                        rxd = resp_q[s_idx][nb-1-(s_cnt-9)];
                    end
                    if (s_on && !prev_fss && sel_frm) s_finish();
                end
            endcase
        end
        prev_sclk = sclk;
        prev_fss  = sel_frm;
    end

    task automatic push_word(input logic [15:0] w);
        @(negedge clk);
        while (tx_full) @(negedge clk);
        tx_wr = 1'b1; tx_wdata = w;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop_check(input logic [15:0] exp, input string req);
        @(negedge clk);
        chk(!rx_empty && rx_rdata == exp, req, "received word", rx_rdata, exp);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic set_cfg(input int fmt, input int size, input int pre,
                           input int dv, input bit pol, input bit pha);
        @(negedge clk);
        while (busy) @(negedge clk);
        cfg_fmt = 2'(fmt); cfg_size = 4'(size); cfg_prescale = 8'(pre);
        cfg_divide = 8'(dv); cfg_cpol = pol; cfg_cpha = pha;
        @(negedge clk); @(negedge clk);
        #1 s_on = 0;
    endtask

    // One batch of frames under one configuration, fully checked.
    task automatic run_batch(input int n, input int fmt, input int size, input int pre,
                             input int dv, input bit pol, input bit pha);
        int base, nb, ef, mask;
        string tag;
        logic [15:0] exp_tx;
        set_cfg(fmt, size, pre, dv, pol, pha);
        base = s_idx; nb = nbits(); ef = eff_fmt();
        mask = (1 << nb) - 1;
        tag = (fmt == 3) ? "R1" : (ef == 0) ? "R6" : (ef == 1) ? "R7" : "R8";
        for (int i = 0; i < n; i++) begin
            tx_q[base+i]   = 16'($urandom);
            resp_q[base+i] = 16'($urandom);
        end
        for (int i = 0; i < n; i++) push_word(tx_q[base+i]);
        while (s_idx < base + n || busy) @(negedge clk);
        chk(sclk == ((ef == 0) ? cfg_cpol : 1'b0), tag, "idle sclk", sclk, (ef == 0) ? cfg_cpol : 0);
        for (int i = 0; i < n; i++) begin
            exp_tx = (ef == 2) ? {8'h00, tx_q[base+i][7:0]} : (tx_q[base+i] & 16'(mask));
            chk(got_q[base+i] == exp_tx, {tag, " R5"}, "wire tx bits", got_q[base+i], exp_tx);
            chk(cnt_q[base+i] == ((ef == 2) ? 9 + nb : nb), {tag, " R2"}, "sample edges",
                cnt_q[base+i], (ef == 2) ? 9 + nb : nb);
            chk(per_q[base+i] == period(pre, dv), "R4", "bit period", per_q[base+i], period(pre, dv));
            if (ef == 2) chk(!bad_q[base+i], "R8", "txd low after command", bad_q[base+i], 0);
            pop_check(resp_q[base+i] & 16'(mask), {tag, " R2 R3"});
        end
    endtask

    initial begin
        int base;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(tx_empty && rx_empty && !tx_full && !rx_full, "R10", "fifo flags",
            {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
        chk(!overrun && !busy, "R10", "overrun/busy", {overrun, busy}, 0);
        chk(sclk == 1'b0 && sel_frm == 1'b1 && txd == 1'b0, "R10", "idle pins",
            {sclk, sel_frm, txd}, 3'b010);

        // Directed corners.
        run_batch(3, 0, 15, 4, 1, 1'b1, 1'b1);  // R6 16-bit, mode 3
        run_batch(3, 0, 7, 2, 0, 1'b0, 1'b0);   // R6 fastest clock
        run_batch(3, 1, 3, 6, 0, 1'b0, 1'b0);   // R7 4-bit
        run_batch(3, 2, 15, 4, 0, 1'b0, 1'b0);  // R8 16-bit response
        run_batch(2, 3, 1, 0, 2, 1'b0, 1'b1);   // R1 code 3, R2 size floor, R4 prescale 0
        run_batch(2, 1, 9, 5, 1, 1'b0, 1'b0);   // R4 odd prescale

        // Random configurations.
        for (int k = 0; k < 10; k++)
            run_batch(3, int'($urandom % 4), int'($urandom % 16), int'($urandom % 9),
                      int'($urandom % 3), 1'($urandom), 1'($urandom));

        // R3 and R9: fill the transmit FIFO, then overflow the receive FIFO.
        set_cfg(0, 7, 20, 1, 1'b0, 1'b0);
        base = s_idx;
        for (int i = 0; i < 10; i++) begin
            tx_q[base+i] = 16'($urandom); resp_q[base+i] = 16'($urandom);
        end
        for (int i = 0; i < 9; i++) push_word(tx_q[base+i]);
        chk(tx_full, "R3", "tx_full after nine writes", tx_full, 1);
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = tx_q[base+9];
        @(negedge clk);
        tx_wr = 1'b0;
        while (!tx_empty || busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(s_idx - base == 9, "R3", "frames after write while full", s_idx - base, 9);
        chk(rx_full && overrun, "R9", "rx_full/overrun", {rx_full, overrun}, 2'b11);
        for (int i = 0; i < 8; i++) pop_check(resp_q[base+i] & 16'h00FF, "R9 R3");
        chk(rx_empty && overrun, "R9", "empty and still overrun", {rx_empty, overrun}, 2'b11);

        // R10: reset clears the sticky flag.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!overrun && rx_empty && tx_empty, "R10", "state after second reset",
            {overrun, rx_empty, tx_empty}, 3'b011);
        summary();
    end
endmodule